// File: doc/BRIEF.md
# Run-Gated Compare-Match Interval Timer

An up-counting interval timer for a processor subsystem. It runs on the system clock, but its count only moves on cycles where a single-cycle `tick` strobe is high. Each strobe marks one falling edge of an externally selected timer clock. Software controls the timer through three register write strobes. A run bit starts and stops it. A compare register sets the interval length. A counter-clear strobe zeroes the count, and it carries no data. The run bit, a live status flag, the count and the compare value can all be read back.

Starting and stopping are synchronised to timer-clock edges. After the run bit is set, the first tick only marks the timer live, and counting starts on the tick after that. After the run bit is cleared, one more tick is still processed as a normal counting edge, and only then does the live flag drop. When the count equals the compare value, the next processed tick wraps the count to zero and raises a one-cycle interrupt pulse. The interrupt interval is therefore the compare value plus one ticks. The interrupt is registered, so `irq` is high in the cycle after the wrapping tick, in the same cycle that `count` reads zero.

None of the interfaces carries a data stream. All pins are plain control and status signals with no back-pressure.

Top module: `match_timer`

## Requirements
- R1: After reset, `run_bit` is 0, `active` is 0, `count` is 0 and `cmp` is all ones (FFh for W=8).
- R2: On a cycle with `tick` low, `active` does not change, and `count` does not change unless `cnt_we` is high.
- R3: A tick while `active` is 0 and `run_bit` is 1 sets `active` to 1 and leaves `count` unchanged.
- R4: A tick while `active` is 1, with no counter write, with `count` not equal to `cmp` and with `cmp` nonzero, increments `count` by one and gives no interrupt.
- R5: A tick while `active` is 1, with no counter write and with `count` equal to `cmp`, sets `count` to 0 and makes `irq` high for exactly the next cycle.
- R6: `irq` is high only in the cycle after a tick, and `count` reads 0 in that cycle.
- R7: A tick while `active` is 1 and `run_bit` is 0 is still processed as a counting edge (increment or wrap with interrupt), and after it `active` is 0.
- R8: While `active` is 0, `count` holds its value, so a restart resumes counting from the held count.
- R9: A `cnt_we` pulse sets `count` to 0 in the next cycle whatever else happens in that cycle, and it suppresses the interrupt even when a match tick coincides with it.
- R10: With `cmp` equal to 0, every processed tick gives an interrupt and `count` stays 0.
- R11: Once counting, interrupts repeat every `cmp`+1 processed ticks, which is 256 ticks for `cmp` equal to FFh.
- R12: A `cmp_we` pulse loads `cmp_wdata` into `cmp`, and a `run_we` pulse loads `run_wdata` into `run_bit`, both visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe per timer-clock falling edge |
| run_we | input | 1 | Write strobe for the run bit |
| run_wdata | input | 1 | New run bit value |
| cmp_we | input | 1 | Write strobe for the compare register |
| cmp_wdata | input | W | New compare value |
| cnt_we | input | 1 | Counter write strobe; the count is cleared |
| run_bit | output | 1 | Current run bit |
| active | output | 1 | Live status: 1 while the timer is counting |
| count | output | W | Current count |
| cmp | output | W | Current compare value |
| irq | output | 1 | One-cycle interrupt pulse on wrap |

## Verification
The bench builds the block with its defaults, W=8 and ZERO_MATCH_ALL=1. At this width the full 256-tick period at compare FFh and the zero-compare case both fit well inside the run. The zero-compare option lets the bench exercise the interrupt-on-every-edge behaviour. Random tick spacing, run toggles and writes that land on tick cycles bring the stop-edge interrupt and the clear-versus-match collision within reach.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [0:0] {
    GATE_IDLE = 1'b0,
    GATE_LIVE = 1'b1
  } gate_e;
endpackage

// File: rtl/tmr_gate.sv
// Start/stop synchroniser: state only moves on ticks.
module tmr_gate
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run_bit,
  output logic live,
  output logic adv
);
  gate_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_IDLE;
    end else if (tick) begin
      unique case (state_q)
        GATE_IDLE: if (run_bit)  state_q <= GATE_LIVE;
        GATE_LIVE: if (!run_bit) state_q <= GATE_IDLE;
        default:   state_q <= GATE_IDLE;
      endcase
    end
  end

  assign live = (state_q == GATE_LIVE);
  // The edge is a counting edge whenever the gate was live before it,
  // including the final edge after run is cleared.
  assign adv  = tick && live;
endmodule

// File: rtl/tmr_count.sv
// Counter with compare, wrap and registered interrupt.
module tmr_count #(
  parameter int W              = 8,
  parameter bit ZERO_MATCH_ALL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         clr,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] count,
  output logic         irq
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic         hit;
  logic [W-1:0] cnt_q;
  logic         irq_q;

  generate
    if (ZERO_MATCH_ALL) begin : g_zero_all
      assign hit = (cnt_q == cmp) || (cmp == ZERO);
    end else begin : g_plain
      assign hit = (cnt_q == cmp);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      irq_q <= 1'b0;
    end else begin
      irq_q <= adv && hit && !clr;
      if (clr)
        cnt_q <= ZERO;
      else if (adv)
        cnt_q <= hit ? ZERO : cnt_q + ONE;
    end
  end

  assign count = cnt_q;
  assign irq   = irq_q;
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int W              = 8,
  parameter bit ZERO_MATCH_ALL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run_we,
  input  logic         run_wdata,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic         cnt_we,
  output logic         run_bit,
  output logic         active,
  output logic [W-1:0] count,
  output logic [W-1:0] cmp,
  output logic         irq
);
  localparam logic [W-1:0] CMP_RST = '1;

  logic         run_q;
  logic [W-1:0] cmp_q;
  logic         adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cmp_q <= CMP_RST;
    end else begin
      if (run_we) run_q <= run_wdata;
      if (cmp_we) cmp_q <= cmp_wdata;
    end
  end

  tmr_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run_bit (run_q),
    .live    (active),
    .adv     (adv)
  );

  tmr_count #(.W(W), .ZERO_MATCH_ALL(ZERO_MATCH_ALL)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .clr   (cnt_we),
    .cmp   (cmp_q),
    .count (count),
    .irq   (irq)
  );

  assign run_bit = run_q;
  assign cmp     = cmp_q;
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         run_we,
  input logic         run_wdata,
  input logic         cmp_we,
  input logic [W-1:0] cmp_wdata,
  input logic         cnt_we,
  input logic         run_bit,
  input logic         active,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp,
  input logic         irq
);
  localparam logic [W-1:0] ZERO = '0;

  a_r2_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(active));
  a_r2_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(count));
  a_r3_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !active && run_bit && !cnt_we) |=> (active && $stable(count)));
  a_r4_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && active && !cnt_we && count != cmp && cmp != ZERO)
      |=> (count == W'($past(count) + 1'b1) && !irq));
  a_r5_wrap_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && active && !cnt_we && count == cmp) |=> (irq && count == ZERO));
  a_r6_irq_shape: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(tick) && count == ZERO));
  a_r7_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && active && !run_bit) |=> !active);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cnt_we) |=> $stable(count));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count == ZERO && !irq));
  a_r12_cmp_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> (cmp == $past(cmp_wdata)));
endmodule

bind match_timer match_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run_we(run_we),
  .run_wdata(run_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
  .cnt_we(cnt_we), .run_bit(run_bit), .active(active), .count(count),
  .cmp(cmp), .irq(irq)
);

// File: tb/match_timer_bench.sv
`timescale 1ns/1ps
module match_timer_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0, run_we = 1'b0, run_wdata = 1'b0;
  logic         cmp_we = 1'b0, cnt_we = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic         run_bit, active, irq;
  logic [W-1:0] count, cmp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  match_timer #(.W(W), .ZERO_MATCH_ALL(1'b1)) u_match_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_we(run_we),
    .run_wdata(run_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .cnt_we(cnt_we), .run_bit(run_bit), .active(active), .count(count),
    .cmp(cmp), .irq(irq)
  );

  // Behavioural model built from the requirements.
  logic         m_run, m_act, m_irq;
  logic [W-1:0] m_cnt, m_cmp;

  function automatic logic is_hit(input logic [W-1:0] c, input logic [W-1:0] k);
    return (c == k) || (k == '0);
  endfunction

  function automatic logic [W-1:0] next_cnt(input logic [W-1:0] c, input logic [W-1:0] k,
                                            input logic a, input logic t, input logic clr);
    if (clr) return '0;
    if (t && a) return is_hit(c, k) ? '0 : c + 1'b1;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 1'b0; m_act <= 1'b0; m_irq <= 1'b0; m_cnt <= '0; m_cmp <= '1;
    end else begin
      if (run_we) m_run <= run_wdata;
      if (cmp_we) m_cmp <= cmp_wdata;
      if (tick) m_act <= m_act ? m_run : m_run;
      m_irq <= tick && m_act && !cnt_we && is_hit(m_cnt, m_cmp);
      m_cnt <= next_cnt(m_cnt, m_cmp, m_act, tick, cnt_we);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One system cycle; inputs set at negedge, outputs sampled at next negedge.
  task automatic cyc(input logic t);
    tick = t;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; run_we = 1'b0; cmp_we = 1'b0; cnt_we = 1'b0;
  endtask

  task automatic set_run(input logic v);
    run_we = 1'b1; run_wdata = v; cyc(1'b0);
  endtask

  task automatic set_cmp(input logic [W-1:0] v);
    cmp_we = 1'b1; cmp_wdata = v; cyc(1'b0);
  endtask

  // Continuous scoreboard against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 R5 model count", count, m_cnt);
      chk("R3 R7 model active", active, m_act);
      chk("R6 model irq", irq, m_irq);
    end
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int irq_seen;
    int gap;
    @(negedge clk);
    @(negedge clk);
    chk("R1 run_bit", run_bit, 0);
    chk("R1 active", active, 0);
    chk("R1 count", count, 0);
    chk("R1 cmp", cmp, 255);
    rst_n = 1'b1;
    @(negedge clk);

    set_cmp(8'd3);
    chk("R12 cmp load", cmp, 3);
    set_run(1'b1);
    chk("R12 run load", run_bit, 1);
    cyc(1'b1);
    chk("R3 active after first tick", active, 1);
    chk("R3 count after first tick", count, 0);
    for (int i = 1; i <= 3; i++) begin
      cyc(1'b1);
      chk("R4 increment", count, i);
      chk("R4 no irq", irq, 0);
    end
    repeat (4) cyc(1'b0);
    chk("R2 count held without tick", count, 3);
    chk("R2 no irq without tick", irq, 0);
    cyc(1'b1);
    chk("R5 wrap count", count, 0);
    chk("R5 irq", irq, 1);
    cyc(1'b0);
    chk("R5 irq one cycle", irq, 0);

    // R11: interval of cmp+1 ticks.
    gap = 0;
    do begin cyc(1'b1); gap++; end while (!irq);
    chk("R11 period cmp=3", gap, 4);

    // R7 and R8: stop with a trailing edge, then resume from held value.
    cyc(1'b1); cyc(1'b1);
    chk("R7 pre-stop count", count, 2);
    set_run(1'b0);
    cyc(1'b1);
    chk("R7 trailing edge counts", count, 3);
    chk("R7 active dropped", active, 0);
    cyc(1'b1); cyc(1'b1);
    chk("R8 count held while stopped", count, 3);
    set_run(1'b1);
    cyc(1'b1);
    chk("R8 restart edge keeps count", count, 3);
    chk("R3 active on restart", active, 1);
    cyc(1'b1);
    chk("R8 resumed to match wrap", irq, 1);

    // R7: trailing edge produces a match interrupt.
    cyc(1'b1); cyc(1'b1); cyc(1'b1);
    chk("R7 at compare", count, 3);
    set_run(1'b0);
    cyc(1'b1);
    chk("R7 stop-edge irq", irq, 1);
    chk("R7 stop-edge wrap", count, 0);
    chk("R7 stopped", active, 0);
    set_run(1'b1);
    cyc(1'b1);

    // R9: clear collides with a match tick.
    cyc(1'b1); cyc(1'b1); cyc(1'b1);
    chk("R9 at compare", count, 3);
    cnt_we = 1'b1;
    cyc(1'b1);
    chk("R9 cleared", count, 0);
    chk("R9 irq suppressed", irq, 0);
    cyc(1'b1); cyc(1'b1);
    cnt_we = 1'b1;
    cyc(1'b0);
    chk("R9 clear without tick", count, 0);

    // R10: compare zero fires every processed tick.
    set_cmp(8'd0);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1);
      chk("R10 irq each tick", irq, 1);
      chk("R10 count stays zero", count, 0);
    end

    // R11: full-width period.
    set_cmp(8'hFF);
    cnt_we = 1'b1; cyc(1'b0);
    gap = 0;
    do begin cyc(1'b1); gap++; end while (!irq && gap < 600);
    chk("R11 period cmp=255", gap, 256);

    // Random phase, scored by the model.
    process::self().srandom(32'd1234);
    irq_seen = 0;
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 99) < 3) begin run_we = 1'b1; run_wdata = ($urandom_range(0, 3) != 0); end
      if ($urandom_range(0, 199) == 0) begin cmp_we = 1'b1; cmp_wdata = W'($urandom_range(0, 12)); end
      if ($urandom_range(0, 299) == 0) cnt_we = 1'b1;
      cyc($urandom_range(0, 2) == 0);
      if (irq) irq_seen++;
    end
    chk("R5 random run produced interrupts", int'(irq_seen > 0), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule